// File: doc/BRIEF.md
# Beat-Note Differentiator and Half-Period Comb Chain

This block cleans up a beat-note signal that has already been decimated to a low sample rate, so that a zero-crossing detector downstream sees fewer disturbances. Each accepted sample first goes through a first-difference stage, d[n] = x[n] - x[n-1]. This stage removes any constant offset and flattens slow drift. Two identical comb stages follow in cascade. Each computes y[n] = u[n] - u[n-D], where D is half the nominal beat period counted in input samples.

At the nominal rate of 2000 samples per second with a 10 Hz beat note, the beat period is 200 samples and D is 100. This places a transfer null at DC and at every multiple of 20 Hz, so the even harmonics at 20, 40, 60 and 80 Hz are rejected. The odd harmonics, including the 10 Hz fundamental, pass with gain. The whole chain works out to out[n] = x[n] - x[n-1] - 2x[n-D] + 2x[n-D-1] + x[n-2D] - x[n-2D-1].

Each stage grows its word by one bit, so the result can never wrap. Every history value from before the first sample after reset is taken as zero. A separate flag marks the outputs whose whole history consisted of real samples.

Top module: `beat_comb_chain`

## Requirements
- R1: In every cycle that follows a clock edge with rst_n low, out_vld, out_settled and out_smp are all zero.
- R2: The first stage subtracts the previous accepted sample from the current one. The value before the first sample after reset counts as zero.
- R3: out_smp is IN_W+3 bits wide, signed two's complement. Any input sequence, including full-scale alternation, produces the exact result without wrap. The largest magnitude is 4*(2^IN_W) - 4.
- R4: Each of the two comb stages subtracts its own input from COMB_DLY strobes earlier (default 100). History from before reset counts as zero. The chain output therefore equals x[n]-x[n-1]-2x[n-D]+2x[n-D-1]+x[n-2D]-x[n-2D-1].
- R5: Each cycle with in_vld high produces exactly one cycle with out_vld high, exactly 3 clock cycles later. out_vld is never high otherwise.
- R6: out_settled is 0 on the first 2*COMB_DLY+1 output strobes after reset and 1 on every output strobe after those.
- R7: Cycles with in_vld low do not change the filter history, and in_smp is ignored in them. out_smp and out_settled hold their values in every cycle without an output strobe. Results depend only on the order of strobes, not on the gaps between them.
- R8: With COMB_DLY at half the beat period, a constant input and any input periodic in COMB_DLY samples give settled outputs of exactly zero. An input periodic in 2*COMB_DLY samples with odd half-wave symmetry gives nonzero settled outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input sample strobe |
| in_smp | input | IN_W | Signed input sample |
| out_vld | output | 1 | Output sample strobe, 3 clocks after in_vld |
| out_smp | output | IN_W+3 | Signed filtered sample |
| out_settled | output | 1 | High when the output's whole history came from real samples |

## Verification
The bench targets the bit-growth limit with a full-scale pattern whose sign flips every COMB_DLY samples, which drives the output to exactly plus and minus 4*(2^IN_W)-4. A stage that is one bit short, or that truncates instead of sign-extending, would wrap at that point. Irregular strobe gaps are filled with a junk value on in_smp. A delay line that advances or captures in idle cycles would then misalign the history and corrupt every later output. The settle boundary at output 2*COMB_DLY+1 is checked strobe by strobe, which exposes an off-by-one in the delay depth or in flag propagation. Inputs that are constant, periodic in COMB_DLY, and periodic in twice COMB_DLY confirm the nulls and the passband, since a wrong delay leaves residue in the nulled cases.

// File: rtl/bcc_pkg.sv
// Package: shared constants and width helpers for the beat-note comb chain.
// Assumes stage 0 is the differentiator and stages 1..BCC_N_COMB are combs,
// each stage adding exactly one bit of growth.
package bcc_pkg;

    localparam int BCC_N_COMB = 2;
    localparam int BCC_GROWTH = 1 + BCC_N_COMB;

    // Width of the output of stage k (0 = differentiator).
    function automatic int bcc_stage_w(input int in_w, input int k);
        return in_w + 1 + k;
    endfunction

    // Bit offset of stage k's output inside the flat chain bus.
    function automatic int bcc_stage_off(input int in_w, input int k);
        return k * (in_w + 1) + (k * (k - 1)) / 2;
    endfunction

endpackage

// File: rtl/bcc_delay_line.sv
// Module: circular delay line of DEPTH words, each with a validity flag.
// The entry read on a push is the one written DEPTH pushes earlier; it is
// overwritten by that same push. Entries reset to zero with the flag clear.
// Assumes DEPTH >= 1.
module bcc_delay_line #(
    parameter int W     = 17,
    parameter int DEPTH = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wr_data,
    input  logic         wr_flag,
    output logic [W-1:0] rd_data,
    output logic         rd_flag
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [DEPTH-1:0] flags;
    logic [AW-1:0]    ptr;

    // Oldest entry is always at the write pointer.
    assign rd_data = mem[ptr];
    assign rd_flag = flags[ptr];

    // Advance the pointer on each push, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (push) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // Store the pushed word and flag; clear all history on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            flags <= '0;
        end else if (push) begin
            mem[ptr]   <= wr_data;
            flags[ptr] <= wr_flag;
        end
    end

endmodule

// File: rtl/bcc_diff.sv
// Module: first-difference stage d[n] = x[n] - x[n-1], registered.
// Output is one bit wider than the input. The sample before the first one
// after reset is zero; out_settled marks outputs built from two real samples.
module bcc_diff #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_smp,
    output logic                out_vld,
    output logic signed [W:0]   out_smp,
    output logic                out_settled
);

    logic signed [W-1:0] prev;
    logic                prev_ok;
    logic signed [W:0]   delta;

    // Sign-extended difference at full output width.
    assign delta = (W+1)'(in_smp) - (W+1)'(prev);

    // Keep the last accepted sample and whether it was real.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev    <= '0;
            prev_ok <= 1'b0;
        end else if (in_vld) begin
            prev    <= in_smp;
            prev_ok <= 1'b1;
        end
    end

    // Register the result and its strobe one clock after the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld     <= 1'b0;
            out_smp     <= '0;
            out_settled <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_smp     <= delta;
                out_settled <= prev_ok;
            end
        end
    end

endmodule

// File: rtl/bcc_comb.sv
// Module: comb stage y[n] = u[n] - u[n-DLY], registered, one bit of growth.
// History before reset is zero. An output is settled when both the current
// input and the delayed one were settled.
module bcc_comb #(
    parameter int W   = 17,
    parameter int DLY = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_smp,
    input  logic                in_settled,
    output logic                out_vld,
    output logic signed [W:0]   out_smp,
    output logic                out_settled
);

    logic [W-1:0]      old_raw;
    logic              old_flag;
    logic signed [W:0] comb_res;

    bcc_delay_line #(
        .W     (W),
        .DEPTH (DLY)
    ) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (in_vld),
        .wr_data (in_smp),
        .wr_flag (in_settled),
        .rd_data (old_raw),
        .rd_flag (old_flag)
    );

    // Current minus delayed sample, both sign-extended.
    assign comb_res = (W+1)'(in_smp) - (W+1)'($signed(old_raw));

    // Register the comb output, its strobe and its settled flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld     <= 1'b0;
            out_smp     <= '0;
            out_settled <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_smp     <= comb_res;
                out_settled <= in_settled & old_flag;
            end
        end
    end

endmodule

// File: rtl/beat_comb_chain.sv
// Module: differentiator followed by BCC_N_COMB cascaded half-period combs.
// Assumes in_vld strobes at the decimated sample rate and COMB_DLY equals half
// the nominal beat period in samples. Latency is one clock per stage.
module beat_comb_chain
    import bcc_pkg::*;
#(
    parameter int IN_W     = 16,
    parameter int COMB_DLY = 100
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_vld,
    input  logic signed [IN_W-1:0]         in_smp,
    output logic                           out_vld,
    output logic signed [IN_W+BCC_GROWTH-1:0] out_smp,
    output logic                           out_settled
);

    localparam int OUT_W   = IN_W + BCC_GROWTH;
    localparam int BUS_W   = bcc_stage_off(IN_W, BCC_N_COMB + 1);
    localparam int LAST_LO = bcc_stage_off(IN_W, BCC_N_COMB);

    // Flat bus holding every stage's output word, stage k at its own offset.
    logic [BUS_W-1:0]    chain_bus;
    logic [BCC_N_COMB:0] stg_vld;
    logic [BCC_N_COMB:0] stg_set;

    bcc_diff #(
        .W (IN_W)
    ) u_diff (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_vld      (in_vld),
        .in_smp      (in_smp),
        .out_vld     (stg_vld[0]),
        .out_smp     (chain_bus[IN_W:0]),
        .out_settled (stg_set[0])
    );

    for (genvar k = 1; k <= BCC_N_COMB; k++) begin : g_comb
        localparam int IW  = bcc_stage_w(IN_W, k - 1);
        localparam int ILO = bcc_stage_off(IN_W, k - 1);
        localparam int OLO = bcc_stage_off(IN_W, k);

        bcc_comb #(
            .W   (IW),
            .DLY (COMB_DLY)
        ) u_comb (
            .clk         (clk),
            .rst_n       (rst_n),
            .in_vld      (stg_vld[k-1]),
            .in_smp      (chain_bus[ILO +: IW]),
            .in_settled  (stg_set[k-1]),
            .out_vld     (stg_vld[k]),
            .out_smp     (chain_bus[OLO +: IW+1]),
            .out_settled (stg_set[k])
        );
    end

    assign out_vld     = stg_vld[BCC_N_COMB];
    assign out_settled = stg_set[BCC_N_COMB];
    assign out_smp     = chain_bus[LAST_LO +: OUT_W];

endmodule

// File: rtl/bcc_checker.sv
// Module: property checker for beat_comb_chain, attached by bind.
// Counts output strobes to locate the settle point without deep $past.
module bcc_checker #(
    parameter int IN_W     = 16,
    parameter int COMB_DLY = 100
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_vld,
    input logic signed [IN_W-1:0] in_smp,
    input logic                   out_vld,
    input logic signed [IN_W+2:0] out_smp,
    input logic                   out_settled
);

    localparam int SETTLE_N = 2 * COMB_DLY + 1;
    localparam int CW       = $clog2(SETTLE_N + 1) + 1;
    localparam longint PEAK = (longint'(1) <<< (IN_W + 2)) - 4;

    logic [CW-1:0] n_out;

    // Saturating count of output strobes since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_out <= '0;
        end else if (out_vld && n_out < CW'(SETTLE_N)) begin
            n_out <= n_out + 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && !out_settled && out_smp == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (longint'(out_smp) <= PEAK && longint'(out_smp) >= -PEAK));

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ##3 out_vld);

    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld, 3));

    p_settle_point_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_settled == (n_out >= CW'(SETTLE_N))));

    p_settled_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_settled |=> out_settled);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> ($stable(out_smp) && $stable(out_settled)));

endmodule

bind beat_comb_chain bcc_checker #(
    .IN_W     (IN_W),
    .COMB_DLY (COMB_DLY)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_vld      (in_vld),
    .in_smp      (in_smp),
    .out_vld     (out_vld),
    .out_smp     (out_smp),
    .out_settled (out_settled)
);

// File: tb/beat_comb_chain_tb.sv
`timescale 1ns/1ps
module beat_comb_chain_tb;

    localparam int IN_W = 16;
    localparam int D    = 100;
    localparam int OUT_W = IN_W + 3;
    localparam int MAXV = (1 << (IN_W - 1)) - 1;
    localparam int MINV = -(1 << (IN_W - 1));

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_vld = 1'b0;
    logic signed [IN_W-1:0]  in_smp = '0;
    logic                    out_vld;
    logic signed [OUT_W-1:0] out_smp;
    logic                    out_settled;

    beat_comb_chain #(.IN_W(IN_W), .COMB_DLY(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_smp(in_smp),
        .out_vld(out_vld), .out_smp(out_smp), .out_settled(out_settled)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int ncyc     = 0;
    bit done     = 0;
    logic rst_seen = 1'b0;

    int hist[$];
    int q_val[$];
    int q_due[$];
    bit q_set[$];

    int st_set, st_nz, st_max, st_min;
    int last_out = 0;
    bit last_set = 0;
    string cur_req = "R2 R4";

    always @(posedge clk) begin
        ncyc     <= ncyc + 1;
        rst_seen <= rst_n;
    end

    function automatic int xh(int idx);
        return (idx < 0) ? 0 : hist[idx];
    endfunction

    task automatic check(bit ok, string req, int act, int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Driver: one strobe, scoreboard push, then idle gap with junk on in_smp (R7).
    task automatic send(int v, int gap);
        int n, e;
        @(negedge clk);
        in_vld = 1'b1;
        in_smp = IN_W'(v);
        hist.push_back(v);
        n = hist.size() - 1;
        e = xh(n) - xh(n-1) - 2*xh(n-D) + 2*xh(n-D-1) + xh(n-2*D) - xh(n-2*D-1);
        q_val.push_back(e);
        q_set.push_back(n >= 2*D + 1);
        q_due.push_back(ncyc + 3);
        @(negedge clk);
        in_vld = 1'b0;
        in_smp = IN_W'(16'h5A5A);
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_vld = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        hist.delete();
    endtask

    task automatic drain_and_clear();
        repeat (6) @(negedge clk);
        check(q_val.size() == 0, "R5", q_val.size(), 0);
        st_set = 0; st_nz = 0; st_max = 0; st_min = 0;
    endtask

    // Monitor: pop expected results on each output strobe; check hold otherwise.
    always @(negedge clk) begin
        if (rst_seen) begin
            if (out_vld) begin
                if (q_val.size() == 0) begin
                    check(0, "R5", 1, 0);
                end else begin
                    int ev, ed;
                    bit es;
                    ev = q_val.pop_front();
                    es = q_set.pop_front();
                    ed = q_due.pop_front();
                    check(ncyc == ed, "R5", ncyc, ed);
                    check(int'(out_smp) == ev, cur_req, int'(out_smp), ev);
                    check(out_settled == es, "R6", int'(out_settled), int'(es));
                    if (out_settled) begin
                        st_set++;
                        if (out_smp != 0) st_nz++;
                        if (int'(out_smp) > st_max) st_max = int'(out_smp);
                        if (int'(out_smp) < st_min) st_min = int'(out_smp);
                    end
                end
            end else begin
                check(int'(out_smp) == last_out && out_settled == last_set, "R7",
                      int'(out_smp), last_out);
            end
        end
        last_out = int'(out_smp);
        last_set = out_settled;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check(out_vld == 1'b0, "R1", int'(out_vld), 0);
        check(out_settled == 1'b0, "R1", int'(out_settled), 0);
        check(out_smp == '0, "R1", int'(out_smp), 0);
        drain_and_clear();

        // General pattern with irregular gaps: R2 R4 R6 R7
        cur_req = "R2 R4 R7";
        for (int n = 0; n < 260; n++) send(((n * 1237) % 20001) - 10000, n % 3);
        drain_and_clear_keep();
        check(st_set == 59, "R6", st_set, 59);

        // Full-scale pattern with sign flipping per block of D: R3
        do_reset();
        drain_and_clear();
        cur_req = "R3";
        for (int n = 0; n < 320; n++)
            send((((n + n / D) % 2) == 0) ? MAXV : MINV, 0);
        repeat (6) @(negedge clk);
        check(st_max == 4*MAXV - 4*MINV, "R3", st_max, 4*MAXV - 4*MINV);
        check(st_min == -(4*MAXV - 4*MINV), "R3", st_min, -(4*MAXV - 4*MINV));

        // Constant input: R8
        do_reset();
        drain_and_clear();
        cur_req = "R8";
        for (int n = 0; n < 250; n++) send(1234, n % 2);
        repeat (6) @(negedge clk);
        check(st_set == 49, "R6", st_set, 49);
        check(st_nz == 0, "R8", st_nz, 0);

        // Triangle periodic in D (20 Hz): nulled, R8
        do_reset();
        drain_and_clear();
        for (int n = 0; n < 250; n++) begin
            int m;
            m = n % D;
            send(((m < D/2) ? m : (D - m)) * 400, 0);
        end
        repeat (6) @(negedge clk);
        check(st_nz == 0, "R8", st_nz, 0);

        // Triangle periodic in 2D (10 Hz): passes, R8
        do_reset();
        drain_and_clear();
        for (int n = 0; n < 300; n++) begin
            int m;
            m = n % (2*D);
            send(((m < D) ? m : (2*D - m)) * 300 - 15000, n % 4 == 0 ? 2 : 0);
        end
        repeat (6) @(negedge clk);
        check(st_nz == 99, "R8", st_nz, 99);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic drain_and_clear_keep();
        repeat (6) @(negedge clk);
        check(q_val.size() == 0, "R5", q_val.size(), 0);
    endtask

endmodule